// File: doc/BRIEF.md
# Quad DAC Serial Frame Controller

This block drives a quad 12-bit DAC over a three-wire serial link: a data line, a serial clock that idles low, and an active-low chip select. It takes a 32-bit command word on a parallel input and sends it as one frame, most significant bit first. Frames repeat without any request. Between frames there is a short gap with chip select high, and in that gap the controller takes a fresh copy of the input word. The DAC samples data on the rising serial clock edge, so the data line changes only while the serial clock is low.

The word is packed for the DAC as follows. Bits 31:24 are zero. Bits 23:20 hold the command, bits 19:16 the channel, bits 15:4 the 12-bit code, and bits 3:0 are zero. The controller does not look inside the word and sends every bit unchanged. The word input has no valid and no back-pressure; the controller pulls from it. `word_taken` is high for the one system cycle at whose closing clock edge the word is copied. A producer that wants a given word in the next frame keeps it on `cmd_word` through that cycle. A change at any other time reaches only a later frame.

With the defaults (`SCK_DIV`=4, `GAP_SCK`=1, `FRAME_BITS`=32), a frame period is 4 + 1 + 128 = 133 system cycles.

Top module: `qdac_frame_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge are `ser_cs_n`=1, `ser_clk`=0, `ser_do`=0 and `word_taken`=0.
- R2: After reset is released, `ser_cs_n` stays high for GAP_SCK*SCK_DIV cycles. `word_taken` is then high for one cycle with `ser_cs_n` still high, and the first frame starts on the following cycle.
- R3: `word_taken` is high for exactly one cycle per frame. The frame that follows carries the `cmd_word` value present in that cycle.
- R4: `ser_cs_n` is low for exactly FRAME_BITS*SCK_DIV consecutive cycles per frame.
- R5: Each bit slot lasts SCK_DIV cycles: `ser_clk` is low for the first SCK_DIV/2 cycles and high for the rest. A frame has exactly FRAME_BITS rising edges, and `ser_clk` is low whenever `ser_cs_n` is high.
- R6: In bit slot k (k=0 first), `ser_do` carries bit FRAME_BITS-1-k of the captured word. `ser_do` never changes while `ser_clk` is high.
- R7: Changing `cmd_word` in any cycle other than the `word_taken` cycle has no effect on the frame in progress.
- R8: Once a frame ends, `ser_cs_n` is high for GAP_SCK*SCK_DIV cycles plus the `word_taken` cycle, and the next frame then starts with no external request.
- R9: `ser_do` is low whenever `ser_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | FRAME_BITS | Parallel command word to send |
| word_taken | output | 1 | One-cycle strobe: `cmd_word` is copied at the end of this cycle |
| ser_do | output | 1 | Serial data, MSB first, changes only while `ser_clk` is low |
| ser_clk | output | 1 | Serial clock, idles low, system clock divided by SCK_DIV |
| ser_cs_n | output | 1 | Active-low chip select, low for a whole frame |

## Verification
All outputs are decoded from registered state, so each one changes in the system cycle that follows the edge that moved the sequencer. The word held in the `word_taken` cycle appears as the first data bit one cycle later. The rising serial clock edge comes SCK_DIV/2 cycles after each bit slot opens, and chip select rises FRAME_BITS*SCK_DIV cycles after it fell. The bench steps a behavioural position counter on every rising edge and compares all four outputs on the falling edge, so expected and actual values are always taken in the same cycle. A receiver clocked by `ser_clk` rebuilds each frame and checks it against the word the model captured, while the stimulus changes `cmd_word` at phases that move through the frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } qdac_state_e;

endpackage

// File: rtl/qdac_seq.sv
module qdac_seq
  import qdac_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        last_bit,
  output qdac_state_e state_o,
  output logic        cs_n_o,
  output logic        rdy_o
);

  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GW-1:0] GLAST = GW'(GAP_CYC - 1);

  qdac_state_e state;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_GAP;
      gap_cnt <= '0;
    end else begin
      case (state)
        ST_GAP: begin
          if (gap_cnt == GLAST) begin
            state   <= ST_LOAD;
            gap_cnt <= '0;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (last_bit) begin
            state <= ST_GAP;
          end
        end
        default: begin
          state   <= ST_GAP;
          gap_cnt <= '0;
        end
      endcase
    end
  end

  assign state_o = state;
  assign cs_n_o  = (state != ST_SHIFT);
  assign rdy_o   = (state == ST_LOAD);

  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rdy_o |=> !rdy_o); // R3
  AST_FRAME_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rdy_o |=> !cs_n_o); // R8
  AST_SHIFT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !last_bit) |=> !cs_n_o); // R4

endmodule

// File: rtl/qdac_sck_gen.sv
module qdac_sck_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  output logic sck_o,
  output logic bit_end_o
);

  localparam int DCW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DCW-1:0] DLAST = DCW'(DIV - 1);
  localparam logic [DCW-1:0] DHALF = DCW'(DIV / 2);

  logic [DCW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
    end else if (shift_en) begin
      if (div_cnt == DLAST) div_cnt <= '0;
      else                  div_cnt <= div_cnt + 1'b1;
    end else begin
      div_cnt <= '0;
    end
  end

  assign bit_end_o = shift_en && (div_cnt == DLAST);
  assign sck_o     = shift_en && (div_cnt >= DHALF);

  AST_SCK_FALL_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(sck_o) |-> $past(bit_end_o)); // R5
  AST_SCK_RISE_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> $past(shift_en)); // R5

endmodule

// File: rtl/qdac_shreg.sv
module qdac_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift_en,
  input  logic         bit_end,
  input  logic [W-1:0] word_i,
  output logic         mosi_o,
  output logic         last_o
);

  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] BLAST = BW'(W - 1);

  logic [W-1:0]  shadow;
  logic [BW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      shadow  <= word_i;
      bit_cnt <= '0;
    end else if (bit_end) begin
      shadow <= {shadow[W-2:0], 1'b0};
      if (bit_cnt == BLAST) bit_cnt <= '0;
      else                  bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign mosi_o = shift_en && shadow[W-1];
  assign last_o = bit_end && (bit_cnt == BLAST);

  AST_LOAD_FRESH: assert property (@(posedge clk) disable iff (rst)
    load |-> (bit_cnt == '0)); // R6
  AST_NO_LOAD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> !load); // R7

endmodule

// File: rtl/qdac_frame_ctrl.sv
module qdac_frame_ctrl
  import qdac_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int SCK_DIV    = 4,
  parameter int GAP_SCK    = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FRAME_BITS-1:0] cmd_word,
  output logic                  word_taken,
  output logic                  ser_do,
  output logic                  ser_clk,
  output logic                  ser_cs_n
);

  localparam int GAP_CYC   = GAP_SCK * SCK_DIV;
  localparam int FRAME_CYC = FRAME_BITS * SCK_DIV;
  localparam int LCW       = $clog2(FRAME_CYC + 1) + 1;

  qdac_state_e state;
  logic        shift_en;
  logic        bit_end;
  logic        last_bit;
  logic        cs_n_w;
  logic        rdy_w;
  logic        sck_w;
  logic        mosi_w;

  qdac_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .last_bit (last_bit),
    .state_o  (state),
    .cs_n_o   (cs_n_w),
    .rdy_o    (rdy_w)
  );

  assign shift_en = (state == ST_SHIFT);

  qdac_sck_gen #(.DIV(SCK_DIV)) u_sck (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .sck_o     (sck_w),
    .bit_end_o (bit_end)
  );

  qdac_shreg #(.W(FRAME_BITS)) u_shr (
    .clk      (clk),
    .rst      (rst),
    .load     (rdy_w),
    .shift_en (shift_en),
    .bit_end  (bit_end),
    .word_i   (cmd_word),
    .mosi_o   (mosi_w),
    .last_o   (last_bit)
  );

  assign word_taken = rdy_w;
  assign ser_do     = mosi_w;
  assign ser_clk    = sck_w;
  assign ser_cs_n   = cs_n_w;

  logic [LCW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst)           low_cnt <= '0;
    else if (!ser_cs_n) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  AST_CS_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (ser_cs_n && !$past(ser_cs_n)) |-> ($past(low_cnt) == LCW'(FRAME_CYC - 1))); // R4
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    ser_cs_n |-> !ser_clk); // R5
  AST_DO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ser_cs_n |-> !ser_do); // R9
  AST_DO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_do)); // R6

endmodule

// File: tb/sim_qdac_frame_ctrl.sv
module sim_qdac_frame_ctrl;
  localparam int FB  = 32;
  localparam int DIV = 4;
  localparam int GAP = 1;
  localparam int GC  = GAP * DIV;
  localparam int PD  = GC + 1 + FB * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [FB-1:0] cmd_word = 32'h0032_4000;
  logic word_taken, ser_do, ser_clk, ser_cs_n;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  qdac_frame_ctrl #(.FRAME_BITS(FB), .SCK_DIV(DIV), .GAP_SCK(GAP)) u0 (
    .clk(clk), .rst(rst), .cmd_word(cmd_word), .word_taken(word_taken),
    .ser_do(ser_do), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n)
  );

  task automatic chk(input string tag, input string what, input logic [FB-1:0] act,
                     input logic [FB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural model: position inside the frame period
  int p = 0;
  bit mrst = 1'b1;
  logic [FB-1:0] mshadow = '0;
  logic [FB-1:0] expq[$];
  int frames_exp = 0;

  always @(posedge clk) begin
    if (rst) begin
      p = 0;
      mrst = 1'b1;
      expq.delete();
    end else begin
      mrst = 1'b0;
      if (p == GC) begin
        mshadow = cmd_word;
        expq.push_back(cmd_word);
      end
      if (p == PD - 1) frames_exp++;
      p = (p + 1) % PD;
    end
  end

  always @(negedge clk) begin
    bit e_cs, e_sck, e_do, e_rdy;
    int k;
    e_rdy = (p == GC);
    e_cs  = !(p > GC);
    e_sck = 1'b0;
    e_do  = 1'b0;
    if (p > GC) begin
      k = p - GC - 1;
      e_sck = (k % DIV) >= (DIV / 2);
      e_do  = mshadow[FB-1-(k / DIV)];
    end
    if (mrst) begin
      chk("R1", "cs_n in reset", {31'd0, ser_cs_n}, 32'd1);
      chk("R1", "clk in reset", {31'd0, ser_clk}, 32'd0);
      chk("R1", "do in reset", {31'd0, ser_do}, 32'd0);
      chk("R1", "taken in reset", {31'd0, word_taken}, 32'd0);
    end else begin
      chk(e_rdy ? "R2" : "R3", "word_taken", {31'd0, word_taken}, {31'd0, e_rdy});
      chk(e_cs ? "R8" : "R4", "ser_cs_n", {31'd0, ser_cs_n}, {31'd0, e_cs});
      chk("R5", "ser_clk", {31'd0, ser_clk}, {31'd0, e_sck});
      chk(e_cs ? "R9" : "R6", "ser_do", {31'd0, ser_do}, {31'd0, e_do});
    end
  end

  // serial receiver
  logic [FB-1:0] rx = '0;
  int nbits = 0;
  int frames_rx = 0;

  always @(posedge ser_clk) begin
    rx = {rx[FB-2:0], ser_do};
    nbits++;
  end

  always @(posedge ser_cs_n) begin
    logic [FB-1:0] w;
    if (rst) begin
      nbits = 0;
    end else begin
      chk("R5", "rising edges per frame", nbits, FB);
      if (expq.size() > 0) begin
        w = expq.pop_front();
        chk("R7", "received frame", rx, w);
      end else begin
        chk("R3", "frame without capture", 32'd1, 32'd0);
      end
      frames_rx++;
      nbits = 0;
    end
  end

  // stimulus
  initial begin
    logic [FB-1:0] lf;
    lf = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2 * PD) @(negedge clk);
    for (int i = 0; i < 6 * PD; i++) begin
      @(negedge clk);
      if (i % 7 == 3) begin
        lf = lf * 32'h0019_660D + 32'h3C6E_F35F;
        cmd_word = lf;
      end
    end
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmd_word = 32'hFFFF_FFF0;
    repeat (PD) @(negedge clk);
    cmd_word = 32'h0000_0000;
    repeat (2 * PD + 10) @(negedge clk);
    chk("R8", "frames received", frames_rx, frames_exp);
    chk("R8", "frames in run", {31'd0, frames_rx > 10}, 32'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule